// File: doc/BRIEF.md
# Three-Wire Serial Register Access Port

This block is the slave end of a three-signal serial link that lets an external host read and write a 256-entry, byte-wide register file. The three signals are a serial clock, an active-low select and one data line that carries data both ways. At the chip boundary the data line is split into an input, an output and an output enable, and the pad joins them. The serial inputs are resynchronised into the system clock domain, and every action happens on a system clock edge.

Every transaction opens with a 16-bit instruction. Its top bit gives the direction, and 1 means read. The next two bits give a length code. The low thirteen bits give a starting address, and only the low eight of them index the register file. One, two, three or an unbounded stream of data bytes follow. After each byte an address generator steps down when bits travel most-significant first and steps up when they travel least-significant first. The bit order comes from a configuration input. Its value is captured when select falls, and the captured copy resets to most-significant first.

Top module: `spi3w_regport`

## Requirements
- R1: While `csN` is high, `sdoEn` stays low and serial clock edges change no register contents.
- R2: Instruction bit 15 chooses read (1) or write (0), bits 14:13 are the length code and bits 7:0 pick the register. Bits 12:8 are ignored, so an address whose upper bits are nonzero aliases to its low byte.
- R3: Length codes 00, 01 and 10 move exactly 1, 2 or 3 bytes. Further bytes sent in the same transaction are ignored.
- R4: Length code 11 streams bytes until select rises. It visits every address in turn and wraps modulo 256.
- R5: In MSB-first order (`cfgLsbFirst`=0) instruction and data bits arrive most significant first, and the address decrements after each byte.
- R6: In LSB-first order (`cfgLsbFirst`=1) bits arrive least significant first, and the address increments after each byte.
- R7: `cfgLsbFirst` is sampled once when select falls. A change during a transaction has no effect until the next one.
- R8: Write bits are taken on rising serial clock edges. Each read bit is presented after a rising edge and holds through the following falling edge, where the host samples it.
- R9: `sdoEn` rises only after all 16 instruction bits of a read. It is never high during a write, and it drops as soon as `csN` goes high.
- R10: If select rises in the middle of a byte or of the instruction, the partial byte is discarded, and the next transaction works normally.
- R11: After reset every register reads 0x00 and the bit order is MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLsbFirst | input | 1 | Bit order for the next transaction (1 = LSB first) |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low transaction select |
| sdi | input | 1 | Data line, input side |
| sdo | output | 1 | Data line, output side |
| sdoEn | output | 1 | Output enable for the data line pad |

## Verification
A wrong address step, or a wrong bit order, lands bytes in the wrong registers, and a readback shows it as soon as the next transaction completes. A wrong byte count or length decode shows as a neighbouring register that changed when it should not, or as stray data after the last byte. An output enable left in the wrong state shows on `sdoEn` within a few system clocks of the last instruction bit or of select rising. A control state that fails to return to idle after an aborted byte corrupts the next transaction's instruction, so the following readback reveals it.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int HDR_W = 16;
  localparam int LEN_MSB = 14;
  localparam int LEN_LSB = 13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DEC, ST_WR, ST_RD, ST_HOLD
  } portState_t;

  typedef struct packed {
    logic startTx;
    logic shiftHdr;
    logic decode;
    logic shiftWr;
    logic writeByte;
    logic shiftRd;
    logic loadNext;
    logic oeClr;
  } portStrobe_t;
endpackage

// File: rtl/spi3w_insync.sv
module spi3w_insync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic sdiIn,
  output logic sclkRise,
  output logic csHigh,
  output logic sdiBit
);
  // bit order within a stage: {sclk, csN, sdi}
  logic [2:0] pipe [SYNC_STAGES];
  logic sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= 3'b010;
      sclkPrev <= 1'b0;
    end else begin
      pipe[0] <= {sclkIn, csNIn, sdiIn};
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
      sclkPrev <= pipe[SYNC_STAGES-1][2];
    end
  end

  assign csHigh   = pipe[SYNC_STAGES-1][1];
  assign sdiBit   = pipe[SYNC_STAGES-1][0];
  assign sclkRise = pipe[SYNC_STAGES-1][2] & ~sclkPrev & ~csHigh;
endmodule

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkRise,
  input  logic        csHigh,
  input  logic        hdrRead,
  input  logic [1:0]  hdrLen,
  output portStrobe_t str
);
  localparam int BIT_W = $clog2(HDR_W);
  localparam logic [BIT_W-1:0] HDR_LAST  = BIT_W'(HDR_W - 1);
  localparam logic [BIT_W-1:0] BYTE_LAST = BIT_W'(DATA_W - 1);

  portState_t state, stateNext;
  logic [BIT_W-1:0] bitCnt;
  logic [1:0] bytesLeft;
  logic stream;
  logic byteEnd, lastByte;

  assign byteEnd  = sclkRise && (bitCnt == BYTE_LAST) &&
                    (state == ST_WR || state == ST_RD);
  assign lastByte = !stream && (bytesLeft == 2'd0);

  always_comb begin
    str = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (!csHigh) begin
        str.startTx = 1'b1;
        stateNext = ST_HDR;
      end
      ST_HDR: if (sclkRise) begin
        str.shiftHdr = 1'b1;
        if (bitCnt == HDR_LAST) stateNext = ST_DEC;
      end
      ST_DEC: begin
        str.decode = 1'b1;
        stateNext = hdrRead ? ST_RD : ST_WR;
      end
      ST_WR: if (sclkRise) begin
        str.shiftWr = 1'b1;
        if (bitCnt == BYTE_LAST) begin
          str.writeByte = 1'b1;
          if (lastByte) stateNext = ST_HOLD;
        end
      end
      ST_RD: if (sclkRise) begin
        if (bitCnt != BYTE_LAST) str.shiftRd = 1'b1;
        else if (lastByte) stateNext = ST_HOLD;
        else str.loadNext = 1'b1;
      end
      default: ;
    endcase
    if (csHigh && state != ST_IDLE) begin
      str = '0;
      str.oeClr = 1'b1;
      stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      bytesLeft <= '0;
      stream <= 1'b0;
    end else begin
      state <= stateNext;
      if (str.startTx || str.decode) bitCnt <= '0;
      else if (byteEnd) bitCnt <= '0;
      else if (sclkRise && state inside {ST_HDR, ST_WR, ST_RD}) bitCnt <= bitCnt + 1'b1;
      if (str.decode) begin
        bytesLeft <= hdrLen;
        stream <= (hdrLen == 2'b11);
      end else if (byteEnd && bytesLeft != 2'd0 && !stream) begin
        bytesLeft <= bytesLeft - 1'b1;
      end
    end
  end

  // R10
  idle_after_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> state == ST_IDLE);

  // R3
  no_write_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> !str.writeByte && !str.loadNext);

  // R2
  header_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HDR && sclkRise && bitCnt != HDR_LAST && !csHigh) |=> state inside {ST_HDR, ST_IDLE});
endmodule

// File: rtl/spi3w_dpath.sv
module spi3w_dpath
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  portStrobe_t str,
  input  logic        sdiBit,
  input  logic        cfgLsbFirst,
  output logic        hdrRead,
  output logic [1:0]  hdrLen,
  output logic        sdoBit,
  output logic        oeReg
);
  localparam int DEPTH = 1 << ADDR_W;

  logic orderLsb;
  logic [HDR_W-1:0] hdrSh, hdrNext;
  logic [DATA_W-1:0] wrSh, wrNext, rdSh;
  logic [ADDR_W-1:0] addr, addrStep, hdrAddr;
  logic [DATA_W-1:0] regFile [DEPTH];

  assign hdrNext  = orderLsb ? {sdiBit, hdrSh[HDR_W-1:1]} : {hdrSh[HDR_W-2:0], sdiBit};
  assign wrNext   = orderLsb ? {sdiBit, wrSh[DATA_W-1:1]} : {wrSh[DATA_W-2:0], sdiBit};
  assign addrStep = orderLsb ? addr + 1'b1 : addr - 1'b1;
  assign hdrAddr  = hdrSh[ADDR_W-1:0];
  assign hdrRead  = hdrSh[HDR_W-1];
  assign hdrLen   = hdrSh[LEN_MSB:LEN_LSB];
  assign sdoBit   = orderLsb ? rdSh[0] : rdSh[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else if (str.writeByte) begin
      regFile[addr] <= wrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      orderLsb <= 1'b0;
      hdrSh <= '0;
      wrSh <= '0;
      rdSh <= '0;
      addr <= '0;
      oeReg <= 1'b0;
    end else begin
      if (str.startTx) begin
        orderLsb <= cfgLsbFirst;
        oeReg <= 1'b0;
      end
      if (str.oeClr) oeReg <= 1'b0;
      if (str.shiftHdr) hdrSh <= hdrNext;
      if (str.shiftWr) wrSh <= wrNext;
      if (str.decode) begin
        addr <= hdrAddr;
        if (hdrRead) begin
          rdSh <= regFile[hdrAddr];
          oeReg <= 1'b1;
        end
      end
      if (str.writeByte) addr <= addrStep;
      if (str.loadNext) begin
        addr <= addrStep;
        rdSh <= regFile[addrStep];
      end
      if (str.shiftRd)
        rdSh <= orderLsb ? {1'b0, rdSh[DATA_W-1:1]} : {rdSh[DATA_W-2:0], 1'b0};
    end
  end

  // R9
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.writeByte |-> !oeReg);

  // R9
  oe_after_header_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeReg) |-> $past(str.decode));

  // R5
  msb_step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((str.writeByte || str.loadNext) && !orderLsb) |=> addr == $past(addr) - 1'b1);

  // R6
  lsb_step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((str.writeByte || str.loadNext) && orderLsb) |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/spi3w_regport.sv
module spi3w_regport
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgLsbFirst,
  input  logic sclk,
  input  logic csN,
  input  logic sdi,
  output logic sdo,
  output logic sdoEn
);
  logic sclkRise, csHigh, sdiBit, hdrRead, sdoBit, oeReg;
  logic [1:0] hdrLen;
  portStrobe_t str;

  spi3w_insync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .csNIn(csN), .sdiIn(sdi),
    .sclkRise(sclkRise), .csHigh(csHigh), .sdiBit(sdiBit));

  spi3w_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .csHigh(csHigh),
    .hdrRead(hdrRead), .hdrLen(hdrLen), .str(str));

  spi3w_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .str(str), .sdiBit(sdiBit),
    .cfgLsbFirst(cfgLsbFirst), .hdrRead(hdrRead), .hdrLen(hdrLen),
    .sdoBit(sdoBit), .oeReg(oeReg));

  assign sdo   = sdoBit;
  assign sdoEn = oeReg & ~csN;
endmodule

// File: tb/sim_spi3w_regport.sv
module sim_spi3w_regport;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLsb = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdoEn;
  int total = 0;
  int bad = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #2 clk = ~clk;

  spi3w_regport u0 (.clk(clk), .rstN(rstN), .cfgLsbFirst(cfgLsb), .sclk(sclk),
    .csN(csN), .sdi(sdi), .sdo(sdo), .sdoEn(sdoEn));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitClk(input logic b);
    @(negedge clk); sclk = 1'b0; sdi = b;
    waitClk(HALF);
    sclk = 1'b1;
    waitClk(HALF);
  endtask

  task automatic sendBits(input logic [15:0] w, input int n, input logic lsb);
    for (int i = 0; i < n; i++) bitClk(lsb ? w[i] : w[n-1-i]);
  endtask

  task automatic startTx(input logic lsb);
    @(negedge clk); cfgLsb = lsb; csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic endTx;
    @(negedge clk); sclk = 1'b0;
    waitClk(HALF);
    csN = 1'b1;
    waitClk(HALF);
  endtask

  task automatic recvByte(input logic lsb, input logic skipFirst, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (!(skipFirst && i == 0)) bitClk(1'b0);
      if (lsb) b[i] = sdo; else b[7-i] = sdo;
    end
  endtask

  task automatic doWrite(input logic lsb, input logic [1:0] len, input logic [12:0] a, input int n);
    startTx(lsb);
    sendBits({1'b0, len, a}, 16, lsb);
    for (int k = 0; k < n; k++) sendBits({8'h00, wbuf[k]}, 8, lsb);
    check("R9 no drive during write", {15'd0, sdoEn}, 16'd0);
    endTx();
  endtask

  task automatic doRead(input logic lsb, input logic [1:0] len, input logic [12:0] a, input int n);
    logic [7:0] b;
    startTx(lsb);
    sendBits({1'b1, len, a}, 16, lsb);
    for (int k = 0; k < n; k++) begin
      recvByte(lsb, k == 0, b);
      rbuf[k] = b;
    end
    endTx();
  endtask

  task automatic readOne(input string req, input logic lsb, input logic [7:0] a, input logic [7:0] exp);
    doRead(lsb, 2'b00, {5'd0, a}, 1);
    check(req, {8'd0, rbuf[0]}, {8'd0, exp});
  endtask

  task automatic testReset;
    check("R11 sdoEn low after reset", {15'd0, sdoEn}, 16'd0);
    readOne("R11 reg 0x00 reset", 1'b0, 8'h00, 8'h00);
    readOne("R11 reg 0xFF reset", 1'b0, 8'hFF, 8'h00);
  endtask

  task automatic testMsbWrite;
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h96;
    doWrite(1'b0, 2'b10, 13'h0012, 3);
    readOne("R5 first byte at 0x12", 1'b0, 8'h12, 8'hA5);
    readOne("R5 second byte at 0x11", 1'b0, 8'h11, 8'h3C);
    readOne("R5 third byte at 0x10", 1'b0, 8'h10, 8'h96);
    readOne("R3 0x0F untouched by 3-byte write", 1'b0, 8'h0F, 8'h00);
    doRead(1'b0, 2'b10, 13'h0012, 3);
    check("R8 burst read byte0", {8'd0, rbuf[0]}, 16'h00A5);
    check("R8 burst read byte1", {8'd0, rbuf[1]}, 16'h003C);
    check("R8 burst read byte2", {8'd0, rbuf[2]}, 16'h0096);
  endtask

  task automatic testLsb;
    wbuf[0] = 8'h1E; wbuf[1] = 8'hC7;
    doWrite(1'b1, 2'b01, 13'h0040, 2);
    readOne("R6 LSB read of 0x41", 1'b1, 8'h41, 8'hC7);
    readOne("R6 MSB cross-read of 0x40", 1'b0, 8'h40, 8'h1E);
    readOne("R6 0x3F untouched", 1'b0, 8'h3F, 8'h00);
    doRead(1'b1, 2'b01, 13'h0040, 2);
    check("R6 LSB burst byte0", {8'd0, rbuf[0]}, 16'h001E);
    check("R6 LSB burst byte1", {8'd0, rbuf[1]}, 16'h00C7);
  endtask

  task automatic testExtraIgnored;
    wbuf[0] = 8'h5A; wbuf[1] = 8'hF0;
    doWrite(1'b0, 2'b00, 13'h0050, 2);
    readOne("R3 single byte written", 1'b0, 8'h50, 8'h5A);
    readOne("R3 extra byte ignored", 1'b0, 8'h4F, 8'h00);
  endtask

  task automatic testHighAddr;
    wbuf[0] = 8'h6D;
    doWrite(1'b0, 2'b00, 13'h1A33, 1);
    readOne("R2 upper address bits alias", 1'b0, 8'h33, 8'h6D);
  endtask

  task automatic testStream;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    doWrite(1'b0, 2'b11, 13'h0001, 3);
    readOne("R4 stream wrap into 0xFF", 1'b0, 8'hFF, 8'h33);
    doRead(1'b0, 2'b11, 13'h0001, 5);
    check("R4 stream byte0", {8'd0, rbuf[0]}, 16'h0011);
    check("R4 stream byte1", {8'd0, rbuf[1]}, 16'h0022);
    check("R4 stream byte2", {8'd0, rbuf[2]}, 16'h0033);
    check("R4 stream byte3", {8'd0, rbuf[3]}, 16'h0000);
    check("R4 stream byte4", {8'd0, rbuf[4]}, 16'h0000);
  endtask

  task automatic testOrderLatch;
    startTx(1'b0);
    @(negedge clk); cfgLsb = 1'b1;
    sendBits({1'b0, 2'b00, 13'h0060}, 16, 1'b0);
    sendBits(16'h00C3, 8, 1'b0);
    endTx();
    readOne("R7 order held for whole transaction", 1'b0, 8'h60, 8'hC3);
  endtask

  task automatic testOutputEnable;
    logic [15:0] h;
    h = {1'b1, 2'b00, 13'h0012};
    startTx(1'b0);
    for (int i = 0; i < 15; i++) bitClk(h[15-i]);
    check("R9 sdoEn low during header", {15'd0, sdoEn}, 16'd0);
    bitClk(h[0]);
    check("R9 sdoEn high after header", {15'd0, sdoEn}, 16'd1);
    check("R8 first read bit", {15'd0, sdo}, 16'd1);
    @(negedge clk); csN = 1'b1;
    #1;
    check("R9 sdoEn drops with select", {15'd0, sdoEn}, 16'd0);
    @(negedge clk); sclk = 1'b0;
    waitClk(HALF);
  endtask

  task automatic testIdle;
    csN = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); sclk = ~sclk; sdi = 1'b1;
      waitClk(3);
      if (sdoEn) check("R1 sdoEn while deselected", 16'd1, 16'd0);
    end
    @(negedge clk); sclk = 1'b0; sdi = 1'b0;
    waitClk(HALF);
    check("R1 sdoEn low while deselected", {15'd0, sdoEn}, 16'd0);
    readOne("R1 reg unchanged after idle edges", 1'b0, 8'h12, 8'hA5);
  endtask

  task automatic testAbort;
    startTx(1'b0);
    sendBits({1'b0, 2'b00, 13'h0070}, 16, 1'b0);
    sendBits(16'h001F, 5, 1'b0);
    endTx();
    readOne("R10 partial byte discarded", 1'b0, 8'h70, 8'h00);
    startTx(1'b0);
    sendBits(16'h007F, 7, 1'b0);
    endTx();
    readOne("R10 recover after header abort", 1'b0, 8'h11, 8'h3C);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testMsbWrite();
    testLsb();
    testExtraIgnored();
    testHighAddr();
    testStream();
    testOrderLatch();
    testOutputEnable();
    testIdle();
    testAbort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule